// File: doc/BRIEF.md
# SPI Controller Interrupt Status Unit

This block holds the interrupt state of a serial peripheral controller. The transfer engine raises three kinds of event: a transmit batch has finished, receive data is ready, or the receive channel has overflowed. Each event sets a bit in a raw status register. Three enable bits in the controller's control word select which raw bits may reach the masked status register. The single interrupt line is high while any masked bit is set.

Software clears raw bits by writing ones to a clear register on a simple write bus. A write to any other address leaves the raw and masked state unchanged, and that includes the addresses of the raw and masked registers themselves.

A parameter selects how the masked register behaves. In sticky mode, masked bits build up and stay set until reset. In plain mode, the masked register follows the AND of the enables and the raw bits, so clearing a raw bit also drops the interrupt.

Top module: `isr_unit`

## Requirements
- R1: When the synchronous reset is high at a clock edge, the raw status, the masked status and the irq output are all zero after that edge.
- R2: An event input pulse that is high at a clock edge sets the matching raw status bit after that edge, and the bit stays set until it is cleared. The bit positions are: 0 for transmit done, 1 for receive ready, 2 for receive overflow. Status bits 3 and above always read zero.
- R3: The enable for raw bit 0 is control bit 5, the enable for raw bit 1 is control bit 4, and the enable for raw bit 2 is control bit 6. All other control bits have no effect. A raw bit that is set while its enable is one appears in the masked status one clock after it appears in the raw status.
- R4: In sticky mode (STICKY=1, the default), a masked bit that is set stays set until reset, even after its raw bit is cleared or its enable is dropped.
- R5: In plain mode (STICKY=0), the masked status equals the AND of the remapped enables and the raw status of the previous cycle, so it falls to zero one clock after the raw bits are cleared or the enables are dropped.
- R6: The irq output is high exactly when at least one masked status bit is set, in the same cycle.
- R7: A bus write to address CLR_ADDR (default 5) clears each raw bit whose data bit (0, 1 or 2) is one. Data bits that are zero leave their raw bit alone, and data bits 3 and above are ignored.
- R8: When an event and a clear for the same raw bit arrive in the same cycle, the raw bit stays set.
- R9: A bus write to any address other than CLR_ADDR changes neither the raw status nor the masked status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 3 | Event pulses from the transfer engine: bit 0 transmit done, bit 1 receive ready, bit 2 receive overflow |
| ctrl_word | input | DATA_W | Control word; bits 5, 4 and 6 are the enables |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register write word address |
| bus_wdata | input | DATA_W | Register write data |
| raw_status | output | DATA_W | Raw status readback, zero-extended |
| masked_status | output | DATA_W | Masked status readback, zero-extended |
| irq | output | 1 | Level interrupt output |

## Verification
The assertions check these properties on every cycle:
- an event sets its raw bit;
- a clear drops a raw bit unless an event arrives with it;
- the raw bits hold when there is neither an event nor a clear;
- irq follows the masked register;
- in sticky mode, masked bits never fall;
- in plain mode, the masked register empties once the raw bits are zero.

Some behaviour can only be shown by the bench's sweeps. These cover the exact remapping of the control bits onto the status order, and that the other control bits and the high data bits are ignored. They also cover that writes to every address other than the clear address leave the state alone, and how the sticky and plain variants differ when the enables are dropped.

// File: rtl/isr_pkg.sv
package isr_pkg;
  localparam int NUM_EVT = 3;

  localparam int BIT_TXDONE = 0;
  localparam int BIT_RXRDY  = 1;
  localparam int BIT_RXOVF  = 2;

  typedef logic [NUM_EVT-1:0] evt_vec_t;

  // control-word position of the enable for each status bit
  function automatic int en_pos(input int status_bit);
    case (status_bit)
      BIT_TXDONE: return 5;
      BIT_RXRDY:  return 4;
      default:    return 6;
    endcase
  endfunction
endpackage

// File: rtl/isr_enable_map.sv
module isr_enable_map
  import isr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] ctrl,
  output evt_vec_t          en
);
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_map
    assign en[i] = ctrl[en_pos(i)];
  end

  logic unused_ctrl;
  assign unused_ctrl = ^ctrl;
endmodule

// File: rtl/isr_raw_reg.sv
module isr_raw_reg
  import isr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  evt_vec_t evt,
  input  evt_vec_t clr,
  output evt_vec_t raw_q
);
  // event has priority over a clear of the same bit
  always_ff @(posedge clk) begin
    if (rst) raw_q <= '0;
    else     raw_q <= (raw_q & ~clr) | evt;
  end

  AST_RAW_RESET: assert property (@(posedge clk)
    rst |=> raw_q == '0); // R1
  AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
    (evt != '0) |=> ((raw_q & $past(evt)) == $past(evt))); // R2
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
    ((clr & ~evt) != '0) |=> ((raw_q & $past(clr & ~evt)) == '0)); // R7
  AST_EVT_BEATS_CLR: assert property (@(posedge clk) disable iff (rst)
    ((clr & evt) != '0) |=> ((raw_q & $past(clr & evt)) == $past(clr & evt))); // R8
  AST_RAW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (clr == '0 && evt == '0) |=> $stable(raw_q)); // R9
endmodule

// File: rtl/isr_mask_reg.sv
module isr_mask_reg
  import isr_pkg::*;
#(
  parameter bit STICKY = 1'b1
) (
  input  logic     clk,
  input  logic     rst,
  input  evt_vec_t en,
  input  evt_vec_t raw,
  output evt_vec_t masked_d,
  output evt_vec_t masked_q
);
  if (STICKY) begin : g_sticky
    always_comb masked_d = masked_q | (en & raw);

    AST_MASK_NEVER_FALLS: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((masked_q & $past(masked_q)) == $past(masked_q))); // R4
  end else begin : g_plain
    always_comb masked_d = en & raw;

    AST_MASK_EMPTIES: assert property (@(posedge clk) disable iff (rst)
      (raw == '0) |=> (masked_q == '0)); // R5
  end

  always_ff @(posedge clk) begin
    if (rst) masked_q <= '0;
    else     masked_q <= masked_d;
  end

  AST_MASK_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    ((en & raw) != '0) |=> ((masked_q & $past(en & raw)) == $past(en & raw))); // R3
endmodule

// File: rtl/isr_unit.sv
module isr_unit
  import isr_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          ADDR_W   = 4,
  parameter bit          STICKY   = 1'b1,
  parameter logic [3:0]  CLR_ADDR = 4'h5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        evt_pulse,
  input  logic [DATA_W-1:0] ctrl_word,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] raw_status,
  output logic [DATA_W-1:0] masked_status,
  output logic              irq
);
  localparam int PAD_W = DATA_W - NUM_EVT;

  evt_vec_t en, clr, raw_q, masked_d, masked_q;
  logic     clr_hit;
  logic     irq_q;

  assign clr_hit = bus_wr && (bus_addr == ADDR_W'(CLR_ADDR));
  assign clr     = clr_hit ? bus_wdata[NUM_EVT-1:0] : '0;

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata[DATA_W-1:NUM_EVT];

  isr_enable_map #(.DATA_W(DATA_W)) u_map (
    .ctrl (ctrl_word),
    .en   (en)
  );

  isr_raw_reg u_raw (
    .clk   (clk),
    .rst   (rst),
    .evt   (evt_pulse),
    .clr   (clr),
    .raw_q (raw_q)
  );

  isr_mask_reg #(.STICKY(STICKY)) u_mask (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .raw      (raw_q),
    .masked_d (masked_d),
    .masked_q (masked_q)
  );

  // registered line aligned with the masked register
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |masked_d;
  end

  assign raw_status    = {{PAD_W{1'b0}}, raw_q};
  assign masked_status = {{PAD_W{1'b0}}, masked_q};
  assign irq           = irq_q;

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq == (masked_status != '0)); // R6
  AST_IRQ_RESET: assert property (@(posedge clk)
    rst |=> !irq); // R1
endmodule

// File: tb/test_isr_unit.sv
module test_isr_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  evt_pulse = '0;
  logic [31:0] ctrl_word = '0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] raw_s, mask_s, raw_p, mask_p;
  logic        irq_s, irq_p;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  isr_unit i_isr_unit (
    .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .ctrl_word(ctrl_word),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .raw_status(raw_s), .masked_status(mask_s), .irq(irq_s)
  );

  isr_unit #(.STICKY(1'b0)) i_isr_unit_plain (
    .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .ctrl_word(ctrl_word),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .raw_status(raw_p), .masked_status(mask_p), .irq(irq_p)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // enables in status order -> control word, with unrelated bits set as noise
  function automatic logic [31:0] ctrl_of(input logic [2:0] en);
    logic [31:0] c;
    c = 32'hFF00_008F;
    c[5] = en[0];
    c[4] = en[1];
    c[6] = en[2];
    return c;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; evt_pulse = '0; bus_wr = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic pulse(input logic [2:0] ev);
    evt_pulse = ev;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    ctrl_word = 32'hFFFF_FFFF;
    evt_pulse = 3'b111;
    repeat (2) @(negedge clk);
    rst = 1'b0; evt_pulse = '0;
    // R1: state after reset even with events and all enables high during it
    chk("R1 raw", raw_s, 0);
    chk("R1 masked", mask_s, 0);
    chk("R1 irq", {31'd0, irq_s}, 0);

    for (int en = 0; en < 8; en++) begin
      for (int ev = 1; ev < 8; ev++) begin
        do_reset();
        ctrl_word = ctrl_of(en[2:0]);
        pulse(ev[2:0]);
        chk("R2 raw set", raw_s, 32'(ev));
        chk("R2 plain raw", raw_p, 32'(ev));
        @(negedge clk);
        chk("R3 masked remap", mask_s, 32'(en & ev));
        chk("R3 plain masked", mask_p, 32'(en & ev));
        chk("R6 irq", {31'd0, irq_s}, {31'd0, (en & ev) != 0});
        wr(4'h5, 32'h0000_0007);
        @(negedge clk);
        chk("R7 clear all", raw_s, 0);
        chk("R4 sticky after clear", mask_s, 32'(en & ev));
        chk("R5 plain drops", mask_p, 0);
        chk("R6 plain irq", {31'd0, irq_p}, 0);
      end
    end

    // R7: each clear pattern with upper data bits set
    for (int c = 0; c < 8; c++) begin
      do_reset();
      ctrl_word = '0;
      pulse(3'b111);
      wr(4'h5, 32'hFFFF_FFF8 | 32'(c));
      chk("R7 selective clear", raw_s, 32'(7 & ~c));
    end

    // R8: event and clear of the same bit in one cycle
    do_reset();
    pulse(3'b111);
    evt_pulse = 3'b010;
    wr(4'h5, 32'h7);
    evt_pulse = '0;
    chk("R8 event beats clear", raw_s, 32'h2);

    // R9: writes to other addresses are ignored
    do_reset();
    ctrl_word = ctrl_of(3'b111);
    pulse(3'b101);
    @(negedge clk);
    for (int a = 0; a < 16; a++) begin
      if (a != 5) begin
        wr(4'(a), 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R9 raw unchanged", raw_s, 32'h5);
        chk("R9 masked unchanged", mask_s, 32'h5);
        chk("R9 plain masked unchanged", mask_p, 32'h5);
      end
    end

    // R4 and R5: enables dropped
    ctrl_word = ctrl_of(3'b000);
    repeat (2) @(negedge clk);
    chk("R4 sticky after enable drop", mask_s, 32'h5);
    chk("R6 sticky irq held", {31'd0, irq_s}, 1);
    chk("R5 plain after enable drop", mask_p, 0);
    chk("R6 plain irq low", {31'd0, irq_p}, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule